// File: doc/BRIEF.md
# I2C Interrupt Status and Mask Unit

This block collects the nine event sources of an I2C controller into one sticky status register and drives a single interrupt line. Six events arrive as one-cycle pulses from the bus engine: transfer done, NACK seen, arbitration lost, receive overflow, slave ready and more data. The other three are detected inside the block. An SCL-low timer flags a bus held low for too long. A host-side guard counts data-port writes and reads to catch FIFO overflow and read underflow.

Software reaches the block through a simple register port. It polls and clears status by writing ones, turns sources on through a write-only enable register and off through a write-only disable register, and reads the resulting mask from a read-only register. The SCL timeout limit is a programmable register whose value is never allowed below a floor.

Top module: `i2c_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, status reads 0, mask reads 0, the timeout limit reads 255 and `irq` is 0.
- R2: Status at offset 0x10 uses this bit map: 0 done, 1 nack, 2 arbitration lost, 3 SCL timeout, 4 receive overflow, 5 host FIFO overflow, 6 host read underflow, 7 slave ready, 8 more data. An event sets its bit, and the bit stays set until a 1 is written to it at 0x10. Writing 0 to a bit leaves it unchanged.
- R3: If an event and a write-1-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Writing 1s to offset 0x24 sets those mask bits and writing 1s to 0x28 clears them. Zero bits in either write leave the mask unchanged. The mask reads at 0x20, and writes to 0x20 are ignored.
- R5: `irq` is the OR of status bits whose mask bit is 1. Status bits set and read back whether or not the source is enabled.
- R6: The timeout limit at 0x1C holds the low 8 bits of a write. A written value below 31 is stored as 31.
- R7: While SCL is low, each sample tick advances a counter. The tick that finds limit ticks already counted sets status bit 3, and only once per low period. SCL high restarts the count.
- R8: With the parameter depth D bytes held, a host data write that is not matched by a same-cycle engine drain sets status bit 5. Each accepted write adds one byte and each drain removes one.
- R9: After a transfer start, the host read numbered size+2 or later (size from `xfer_size`) sets status bit 6.
- R10: A FIFO clear pulse empties the held-byte count and the host read count.
- R11: Reads of 0x24, 0x28 and of any unmapped offset return 0. Read data appears on `reg_rdata` one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, registered |
| evt_done | input | 1 | Engine pulse: transfer complete |
| evt_nack | input | 1 | Engine pulse: NACK received |
| evt_arb_lost | input | 1 | Engine pulse: arbitration lost |
| evt_rx_ovf | input | 1 | Engine pulse: receive overflow |
| evt_slave_rdy | input | 1 | Engine pulse: slave acknowledged |
| evt_more_data | input | 1 | Engine pulse: more data in flight |
| scl_in | input | 1 | Synchronised SCL level |
| sample_tick | input | 1 | Oversampling tick enable |
| host_push | input | 1 | Host wrote the data port |
| host_pop | input | 1 | Host read the data port |
| tx_drain | input | 1 | Engine removed a byte from the transmit FIFO |
| fifo_clear | input | 1 | FIFO clear pulse |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_size | input | TSIZE_W (8) | Programmed transfer size |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a FIFO depth of 4 instead of 16, so the overflow boundary is reached after only four writes. It also exercises drain, clear, and a write paired with a drain at the full mark. The timeout limit keeps its 8-bit width and its floor of 31, so the bench reaches the exact firing tick in a few dozen cycles, and it also covers the once-per-low-period rule and the restart on SCL high. A transfer size of 2 puts the underflow boundary at the fourth read.

// File: rtl/i2c_irq_pkg.sv
// Shared constants for the I2C interrupt unit: source bit positions and
// register offsets. Assumes byte offsets fit in 8 bits.
package i2c_irq_pkg;
    localparam int NSRC = 9;

    localparam int SRC_DONE    = 0;
    localparam int SRC_NACK    = 1;
    localparam int SRC_ARB     = 2;
    localparam int SRC_TMO     = 3;
    localparam int SRC_RXOVF   = 4;
    localparam int SRC_HOVF    = 5;
    localparam int SRC_HUNF    = 6;
    localparam int SRC_SLVRDY  = 7;
    localparam int SRC_MORE    = 8;

    localparam logic [7:0] OFS_STATUS  = 8'h10;
    localparam logic [7:0] OFS_TIMEOUT = 8'h1C;
    localparam logic [7:0] OFS_MASK    = 8'h20;
    localparam logic [7:0] OFS_ENABLE  = 8'h24;
    localparam logic [7:0] OFS_DISABLE = 8'h28;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_scl_timer.sv
// SCL-low watchdog. It holds a programmable limit (never below TMO_MIN) and
// counts sample ticks while SCL is low. It fires one pulse per low period,
// on the tick that finds `limit` ticks already counted.
// Assumes scl_i is already synchronised to clk.
module irq_scl_timer #(
    parameter int TMO_W   = 8,
    parameter int TMO_MIN = 31,
    parameter int TMO_RST = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [TMO_W-1:0] wdata_i,
    output logic [TMO_W-1:0] limit_o,
    input  logic             scl_i,
    input  logic             tick_i,
    output logic             fire_o
);
    localparam logic [TMO_W-1:0] LIM_FLOOR = TMO_W'(TMO_MIN);
    localparam logic [TMO_W-1:0] LIM_RESET = TMO_W'(TMO_RST);

    logic [TMO_W-1:0] limit_q;
    logic [TMO_W:0]   cnt_q;

    // Limit register with floor clamp on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= LIM_RESET;
        else if (wr_i)
            limit_q <= (wdata_i < LIM_FLOOR) ? LIM_FLOOR : wdata_i;
    end

    // Low-time counter: restarts on SCL high, saturates just past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (scl_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q <= {1'b0, limit_q})
            cnt_q <= cnt_q + 1'b1;
    end

    assign fire_o  = tick_i && !scl_i && (cnt_q == {1'b0, limit_q});
    assign limit_o = limit_q;

    assert_limit_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        limit_q >= LIM_FLOOR);
    assert_fire_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i |=> !fire_o);
endmodule

// File: rtl/irq_host_guard.sv
// Host-side FIFO misuse detector. It tracks how many bytes the host has
// placed in the transmit FIFO (drained by the engine) and how many reads
// the host has made since the transfer started. It pulses ovf_o on a write
// into a full FIFO and unf_o on a read beyond size+1.
module irq_host_guard #(
    parameter int DEPTH   = 16,
    parameter int TSIZE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic               drain_i,
    input  logic               clear_i,
    input  logic               start_i,
    input  logic [TSIZE_W-1:0] size_i,
    output logic               ovf_o,
    output logic               unf_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [TSIZE_W:0] RD_MAX = '1;

    logic [CW-1:0]    occ_q;
    logic [TSIZE_W:0] rd_q;
    logic             accept, take;

    assign take   = drain_i && (occ_q != '0);
    assign accept = push_i && ((occ_q != FULL) || drain_i);
    assign ovf_o  = push_i && !accept && !clear_i;
    assign unf_o  = pop_i && !clear_i && !start_i && (rd_q > {1'b0, size_i});

    // Occupancy of the transmit FIFO as seen from the host side.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            occ_q <= '0;
        else
            occ_q <= occ_q + CW'(accept) - CW'(take);
    end

    // Host reads since transfer start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || start_i)
            rd_q <= '0;
        else if (pop_i && rd_q != RD_MAX)
            rd_q <= rd_q + 1'b1;
    end

    assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL);
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (occ_q == '0 && rd_q == '0));
endmodule

// File: rtl/irq_status_mask.sv
// Sticky status bits with write-1-to-clear, where an event beats a clear,
// and a mask set by enable strobes and cleared by disable strobes. The
// interrupt is the OR of enabled status bits. Assumes en_i and dis_i never
// carry ones in the same cycle (they come from different offsets).
module irq_status_mask #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] dis_i,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] mask_o,
    output logic            irq_o
);
    logic [NSRC-1:0] stat_q, mask_q;

    for (genvar k = 0; k < NSRC; k++) begin : g_bit
        // Status bit: set by event, cleared by W1C, event has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[k] <= 1'b0;
            else if (ev_i[k])
                stat_q[k] <= 1'b1;
            else if (clr_i[k])
                stat_q[k] <= 1'b0;
        end

        // Mask bit: set by enable strobe, cleared by disable strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[k] <= 1'b0;
            else if (en_i[k])
                mask_q[k] <= 1'b1;
            else if (dis_i[k])
                mask_q[k] <= 1'b0;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign irq_o  = |(stat_q & mask_q);

    assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((stat_q & $past(ev_i)) == $past(ev_i)));
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    assert_enable_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i != '0) |=> ((mask_q & $past(en_i)) == $past(en_i)));
    assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i != '0) |=> ((mask_q & $past(dis_i)) == '0));
endmodule

// File: rtl/i2c_irq_unit.sv
// I2C interrupt status and mask unit. It decodes the register port, gathers
// engine pulses and the internal timeout and host-misuse events into the
// sticky status register, and drives irq. Read data is registered one cycle
// after the read strobe. Assumes engine event inputs are single-cycle pulses.
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int TSIZE_W    = 8,
    parameter int TMO_W      = 8,
    parameter int TMO_MIN    = 31,
    parameter int TMO_RST    = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               evt_done,
    input  logic               evt_nack,
    input  logic               evt_arb_lost,
    input  logic               evt_rx_ovf,
    input  logic               evt_slave_rdy,
    input  logic               evt_more_data,
    input  logic               scl_in,
    input  logic               sample_tick,
    input  logic               host_push,
    input  logic               host_pop,
    input  logic               tx_drain,
    input  logic               fifo_clear,
    input  logic               xfer_start,
    input  logic [TSIZE_W-1:0] xfer_size,
    output logic               irq
);
    localparam int PAD_S = DW - NSRC;
    localparam int PAD_T = DW - TMO_W;

    logic     hit_stat, hit_tmo, hit_mask, hit_en, hit_dis;
    src_vec_t ev, clr, en, dis, stat, mask;
    logic     tmo_fire, h_ovf, h_unf;
    logic [TMO_W-1:0] limit;
    logic [DW-1:0]    rdata_q;

    assign hit_stat = (reg_addr == AW'(OFS_STATUS));
    assign hit_tmo  = (reg_addr == AW'(OFS_TIMEOUT));
    assign hit_mask = (reg_addr == AW'(OFS_MASK));
    assign hit_en   = (reg_addr == AW'(OFS_ENABLE));
    assign hit_dis  = (reg_addr == AW'(OFS_DISABLE));

    assign clr = (reg_wr && hit_stat) ? reg_wdata[NSRC-1:0] : '0;
    assign en  = (reg_wr && hit_en)   ? reg_wdata[NSRC-1:0] : '0;
    assign dis = (reg_wr && hit_dis)  ? reg_wdata[NSRC-1:0] : '0;

    // Gather every event source into its status bit position.
    always_comb begin
        ev             = '0;
        ev[SRC_DONE]   = evt_done;
        ev[SRC_NACK]   = evt_nack;
        ev[SRC_ARB]    = evt_arb_lost;
        ev[SRC_TMO]    = tmo_fire;
        ev[SRC_RXOVF]  = evt_rx_ovf;
        ev[SRC_HOVF]   = h_ovf;
        ev[SRC_HUNF]   = h_unf;
        ev[SRC_SLVRDY] = evt_slave_rdy;
        ev[SRC_MORE]   = evt_more_data;
    end

    irq_scl_timer #(.TMO_W(TMO_W), .TMO_MIN(TMO_MIN), .TMO_RST(TMO_RST)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr && hit_tmo),
        .wdata_i (reg_wdata[TMO_W-1:0]),
        .limit_o (limit),
        .scl_i   (scl_in),
        .tick_i  (sample_tick),
        .fire_o  (tmo_fire)
    );

    irq_host_guard #(.DEPTH(FIFO_DEPTH), .TSIZE_W(TSIZE_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (host_push),
        .pop_i   (host_pop),
        .drain_i (tx_drain),
        .clear_i (fifo_clear),
        .start_i (xfer_start),
        .size_i  (xfer_size),
        .ovf_o   (h_ovf),
        .unf_o   (h_unf)
    );

    irq_status_mask #(.NSRC(NSRC)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .clr_i  (clr),
        .en_i   (en),
        .dis_i  (dis),
        .stat_o (stat),
        .mask_o (mask),
        .irq_o  (irq)
    );

    // Registered read mux; write-only and unmapped offsets read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (reg_rd) begin
            if (hit_stat)
                rdata_q <= {{PAD_S{1'b0}}, stat};
            else if (hit_mask)
                rdata_q <= {{PAD_S{1'b0}}, mask};
            else if (hit_tmo)
                rdata_q <= {{PAD_T{1'b0}}, limit};
            else
                rdata_q <= '0;
        end
    end

    assign reg_rdata = rdata_q;

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: tb/test_i2c_irq_unit.sv
module test_i2c_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_done = 0, evt_nack = 0, evt_arb_lost = 0, evt_rx_ovf = 0;
    logic        evt_slave_rdy = 0, evt_more_data = 0;
    logic        scl_in = 1, sample_tick = 0;
    logic        host_push = 0, host_pop = 0, tx_drain = 0, fifo_clear = 0, xfer_start = 0;
    logic [7:0]  xfer_size = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 0;

    always #10 clk = ~clk;

    i2c_irq_unit #(.FIFO_DEPTH(4)) i_i2c_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_done(evt_done), .evt_nack(evt_nack), .evt_arb_lost(evt_arb_lost),
        .evt_rx_ovf(evt_rx_ovf), .evt_slave_rdy(evt_slave_rdy),
        .evt_more_data(evt_more_data), .scl_in(scl_in), .sample_tick(sample_tick),
        .host_push(host_push), .host_pop(host_pop), .tx_drain(tx_drain),
        .fifo_clear(fifo_clear), .xfer_start(xfer_start), .xfer_size(xfer_size),
        .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard one cycle after each read strobe.
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    // Driver: issues a read and pushes its expected value.
    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic evts(logic [5:0] v);
        @(negedge clk);
        {evt_more_data, evt_slave_rdy, evt_rx_ovf, evt_arb_lost, evt_nack, evt_done} = v;
        @(negedge clk);
        {evt_more_data, evt_slave_rdy, evt_rx_ovf, evt_arb_lost, evt_nack, evt_done} = '0;
    endtask

    task automatic host(bit p, bit q, bit d, int n);
        @(negedge clk);
        host_push = p; host_pop = q; tx_drain = d;
        repeat (n) @(negedge clk);
        host_push = 0; host_pop = 0; tx_drain = 0;
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        sample_tick = 1;
        repeat (n) @(negedge clk);
        sample_tick = 0;
    endtask

    task automatic chk_irq(logic e, string tag);
        @(negedge clk);
        check(tag, {31'b0, irq}, {31'b0, e});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(8'h10, 32'h0, "R1 status");
        rd(8'h20, 32'h0, "R1 mask");
        rd(8'h1C, 32'd255, "R1 limit");
        chk_irq(0, "R1 irq");
        // R2 sticky, write 0 ignored; R11 zero reads
        evts(6'b000001);
        rd(8'h10, 32'h001, "R2 done set");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h001, "R2 write0 keeps");
        rd(8'h30, 32'h0, "R11 unmapped");
        rd(8'h24, 32'h0, "R11 enable reads 0");
        chk_irq(0, "R5 masked irq low");
        // R4/R5 enable, mask write ignored
        wr(8'h24, 32'h001);
        rd(8'h20, 32'h001, "R4 enable");
        chk_irq(1, "R5 irq on enabled bit");
        wr(8'h20, 32'h1FF);
        rd(8'h20, 32'h001, "R4 mask write ignored");
        wr(8'h10, 32'h001);
        rd(8'h10, 32'h0, "R2 w1c");
        chk_irq(0, "R5 irq after clear");
        // R3 event beats clear
        evts(6'b000010);
        @(negedge clk);
        evt_nack = 1; reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'h002;
        @(negedge clk);
        evt_nack = 0; reg_wr = 0;
        rd(8'h10, 32'h002, "R3 event wins");
        chk_irq(0, "R5 nack not enabled");
        // R4 disable
        wr(8'h24, 32'h1FF);
        chk_irq(1, "R5 irq all enabled");
        wr(8'h28, 32'h002);
        rd(8'h28, 32'h0, "R11 disable reads 0");
        rd(8'h20, 32'h1FD, "R4 disable");
        chk_irq(0, "R5 irq after disable");
        wr(8'h10, 32'h1FF);
        evts(6'b111111);
        rd(8'h10, 32'h197, "R2 engine bit map");
        wr(8'h10, 32'h1FF);
        rd(8'h10, 32'h0, "R2 clear all");
        // R6 limit clamp
        wr(8'h1C, 32'd200);
        rd(8'h1C, 32'd200, "R6 limit 200");
        wr(8'h1C, 32'd5);
        rd(8'h1C, 32'd31, "R6 clamp to 31");
        // R7 timeout
        @(negedge clk); scl_in = 0;
        ticks(31);
        rd(8'h10, 32'h0, "R7 not yet at 31 ticks");
        ticks(1);
        rd(8'h10, 32'h008, "R7 fires at 32nd tick");
        chk_irq(1, "R7 irq timeout");
        wr(8'h10, 32'h008);
        ticks(10);
        rd(8'h10, 32'h0, "R7 once per low period");
        @(negedge clk); scl_in = 1;
        @(negedge clk); scl_in = 0;
        ticks(31);
        rd(8'h10, 32'h0, "R7 restart after high");
        ticks(1);
        rd(8'h10, 32'h008, "R7 fires after restart");
        @(negedge clk); scl_in = 1;
        wr(8'h10, 32'h1FF);
        // R8 overflow at depth 4
        host(1, 0, 0, 4);
        rd(8'h10, 32'h0, "R8 four writes fit");
        host(1, 0, 0, 1);
        rd(8'h10, 32'h020, "R8 fifth write overflows");
        wr(8'h10, 32'h020);
        host(1, 0, 1, 1);
        rd(8'h10, 32'h0, "R8 write with drain at full");
        host(0, 0, 1, 1);
        host(1, 0, 0, 1);
        rd(8'h10, 32'h0, "R8 drain frees a slot");
        host(1, 0, 0, 1);
        rd(8'h10, 32'h020, "R8 full again");
        wr(8'h10, 32'h020);
        // R10 clear
        @(negedge clk); fifo_clear = 1;
        @(negedge clk); fifo_clear = 0;
        host(1, 0, 0, 4);
        rd(8'h10, 32'h0, "R10 clear empties occupancy");
        // R9 underflow
        xfer_size = 8'd2;
        @(negedge clk); xfer_start = 1;
        @(negedge clk); xfer_start = 0;
        host(0, 1, 0, 3);
        rd(8'h10, 32'h0, "R9 three reads allowed");
        host(0, 1, 0, 1);
        rd(8'h10, 32'h040, "R9 fourth read underflows");
        wr(8'h10, 32'h1FF);
        @(negedge clk); xfer_start = 1;
        @(negedge clk); xfer_start = 0;
        host(0, 1, 0, 3);
        rd(8'h10, 32'h0, "R9 start restarts count");
        @(negedge clk); fifo_clear = 1;
        @(negedge clk); fifo_clear = 0;
        host(0, 1, 0, 3);
        rd(8'h10, 32'h0, "R10 clear restarts reads");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule